// File: doc/BRIEF.md
# Adaptive DRAM Command Throttle

This block sits on the path from a memory controller's command scheduler to the DRAM. It raises a stall signal on each cycle when no command may be issued, which keeps the average DRAM activity close to a power target. Time is split into fixed windows of `WINDOW_LEN` cycles. In every window, stall is high for the first T cycles and low for the rest.

The value of T is not fixed. The scheduler sends one-cycle event pulses for each read, each write and each bank conflict. The block counts these over a long epoch of `EPOCH_LEN` cycles. When the epoch closes, it evaluates a linear estimator: T = round(k0 + k1·P + k2·R + k3·W + k4·B). The coefficients are signed fixed point with `FRAC_W` fractional bits. The result is limited to the range 0 to `WINDOW_LEN`. Software writes the coefficients and the power target P once during system setup, and the hardware never changes them.

The result computed from one epoch is used for the following epoch. It takes effect at a window boundary, so a window is never cut short part-way through. The evaluation is either a five-step serial multiply-accumulate or a single-cycle parallel sum, chosen by a parameter.

Top module: `dram_throttle_ctrl`

## Requirements
- R1: After reset, `throttle_delay` is 0 and `stall` is low, and both stay that way until the first estimate is applied.
- R2: Window position p counts 0 to WINDOW_LEN-1 from reset and then wraps to 0. `stall` is high exactly when p < `throttle_delay`, so it covers one contiguous run at the start of each window.
- R3: When `throttle_delay` is 0, `stall` is never raised. When `throttle_delay` is WINDOW_LEN, `stall` is high on every cycle.
- R4: One epoch counts the read, write and conflict pulses on its cycles 0 to EPOCH_LEN-2. A pulse on the epoch's final cycle is counted in the next epoch.
- R5: The estimate is floor((S + 2^(FRAC_W-1)) / 2^FRAC_W), where S = k0 + k1·P + k2·R + k3·W + k4·B. So halves round upward.
- R6: A result below 0 gives 0, and a result above WINDOW_LEN gives WINDOW_LEN.
- R7: The estimate from an epoch that ends on cycle E is loaded at the window boundary after cycle E+WINDOW_LEN. This is the second boundary after the epoch end. `throttle_delay` then holds that value until the next load.
- R8: Each event count saturates at 2^CNT_W-1 within one epoch.
- R9: A write with `cfg_we` high stores `cfg_wdata` according to `cfg_addr`: address 0 is k0, 1 is k1, 2 is k2, 3 is k3, 4 is k4, and 5 is P (low PWR_W bits). Writes to addresses 6 and 7 change nothing.
- R10: The coefficients are two's-complement signed values, so negative coefficients lower the estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | COEF_W | Configuration write data |
| ev_read | input | 1 | One pulse per read issued |
| ev_write | input | 1 | One pulse per write issued |
| ev_conflict | input | 1 | One pulse per bank conflict |
| stall | output | 1 | High: hold all DRAM commands this cycle |
| throttle_delay | output | $clog2(WINDOW_LEN+1) | Stall length T currently in force |

## Verification
The bound checker checks the window-shape properties on every cycle:
- `stall` forms one contiguous run at the start of each window.
- `throttle_delay` stays within range.
- The two extreme delays behave as required.
- `throttle_delay` changes only when a window starts.

The checker cannot see the arithmetic: the counting of events, rounding, saturation of counts, the signed coefficients, how events on the epoch's last cycle are assigned, and the ignored register addresses. These show up only when the bench's behavioural model and its scenario epochs predict a particular T, which the bench then compares against the outputs.

// File: rtl/thr_pkg.sv
package thr_pkg;

   // number of estimator terms: bias, power target, reads, writes, conflicts
   localparam int NUM_TERMS = 5;
   // number of counted scheduler events
   localparam int NUM_EV    = 3;

   // configuration register selector; order defines the term index
   typedef enum logic [2:0] {
      CFG_BIAS    = 3'd0,
      CFG_K_PWR   = 3'd1,
      CFG_K_RD    = 3'd2,
      CFG_K_WR    = 3'd3,
      CFG_K_CONF  = 3'd4,
      CFG_TARGET  = 3'd5
   } cfg_sel_e;

   // event slot positions inside the counter bank
   localparam int EV_RD = 0;
   localparam int EV_WR = 1;
   localparam int EV_CF = 2;

   // first estimator term fed by an event count
   localparam int TERM_EV0 = 2;

endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
   import thr_pkg::*;
#(
   parameter int COEF_W = 16,
   parameter int PWR_W  = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 we,
   input  logic [2:0]                           addr,
   input  logic [COEF_W-1:0]                    wdata,
   output logic [NUM_TERMS-1:0][COEF_W-1:0]     coef,
   output logic [PWR_W-1:0]                     target
);

   logic [NUM_TERMS-1:0][COEF_W-1:0] coef_q;
   logic [PWR_W-1:0]                 target_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_q   <= '0;
         target_q <= '0;
      end else if (we) begin
         for (int i = 0; i < NUM_TERMS; i++) begin
            if (addr == 3'(i)) coef_q[i] <= wdata;
         end
         if (addr == CFG_TARGET) target_q <= wdata[PWR_W-1:0];
      end
   end

   assign coef   = coef_q;
   assign target = target_q;

endmodule

// File: rtl/thr_event_counters.sv
module thr_event_counters
   import thr_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_EV-1:0]                 ev,
   input  logic                              epoch_end,
   output logic [NUM_EV-1:0][CNT_W-1:0]      snap
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   for (genvar g = 0; g < NUM_EV; g++) begin : g_ctr
      logic [CNT_W-1:0] run_q;
      logic [CNT_W-1:0] snap_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q  <= '0;
            snap_q <= '0;
         end else if (epoch_end) begin
            // close the epoch; an event on this cycle opens the next one
            snap_q <= run_q;
            run_q  <= ev[g] ? CNT_W'(1) : '0;
         end else if (ev[g] && run_q != CNT_MAX) begin
            run_q  <= run_q + CNT_W'(1);
         end
      end

      assign snap[g] = snap_q;
   end

endmodule

// File: rtl/thr_estimator.sv
module thr_estimator
   import thr_pkg::*;
#(
   parameter int WINDOW_LEN = 10000,
   parameter int CNT_W      = 20,
   parameter int COEF_W     = 16,
   parameter int PWR_W      = 16,
   parameter int FRAC_W     = 8,
   parameter bit SERIAL_MAC = 1'b1,
   localparam int WIN_W     = $clog2(WINDOW_LEN + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [NUM_TERMS-1:0][COEF_W-1:0]  coef,
   input  logic [PWR_W-1:0]                  target,
   input  logic [NUM_EV-1:0][CNT_W-1:0]      counts,
   output logic                              res_valid,
   output logic [WIN_W-1:0]                  res
);

   localparam int FEAT_W = (CNT_W > PWR_W) ? CNT_W : PWR_W;
   localparam int PROD_W = COEF_W + FEAT_W + 1;
   localparam int ACC_W  = PROD_W + $clog2(NUM_TERMS) + 1;
   localparam int HALF   = 1 << (FRAC_W - 1);
   localparam int IDX_W  = $clog2(NUM_TERMS);

   // feature vector: constant one, power target, then the event counts
   logic [NUM_TERMS-1:0][FEAT_W-1:0] feat;

   always_comb begin
      feat    = '0;
      feat[0] = FEAT_W'(1);
      feat[1] = FEAT_W'(target);
      for (int j = 0; j < NUM_EV; j++) begin
         feat[TERM_EV0 + j] = FEAT_W'(counts[j]);
      end
   end

   function automatic logic signed [PROD_W-1:0] term_prod(
      input logic [COEF_W-1:0] c,
      input logic [FEAT_W-1:0] f
   );
      logic signed [PROD_W-1:0] ce;
      logic signed [PROD_W-1:0] fe;
      ce = PROD_W'($signed(c));
      fe = $signed(PROD_W'({1'b0, f}));
      return ce * fe;
   endfunction

   function automatic logic [WIN_W-1:0] round_clamp(
      input logic signed [ACC_W-1:0] a
   );
      logic signed [ACC_W-1:0] r;
      r = a + $signed(ACC_W'(HALF));
      r = r >>> FRAC_W;
      if (r < 0)                                 return '0;
      if (r > $signed(ACC_W'(WINDOW_LEN)))       return WIN_W'(WINDOW_LEN);
      return r[WIN_W-1:0];
   endfunction

   if (SERIAL_MAC) begin : g_serial
      logic                     busy_q;
      logic                     done_q;
      logic [IDX_W-1:0]         idx_q;
      logic signed [ACC_W-1:0]  acc_q;
      logic signed [PROD_W-1:0] prod;

      assign prod = term_prod(coef[idx_q], feat[idx_q]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            idx_q     <= '0;
            acc_q     <= '0;
            res_valid <= 1'b0;
            res       <= '0;
         end else begin
            res_valid <= 1'b0;
            if (start) begin
               busy_q <= 1'b1;
               done_q <= 1'b0;
               idx_q  <= '0;
               acc_q  <= '0;
            end else if (busy_q) begin
               acc_q <= acc_q + ACC_W'(prod);
               if (idx_q == IDX_W'(NUM_TERMS - 1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end else if (done_q) begin
               done_q    <= 1'b0;
               res       <= round_clamp(acc_q);
               res_valid <= 1'b1;
            end
         end
      end
   end else begin : g_parallel
      logic                     go_q;
      logic signed [ACC_W-1:0]  sum;

      always_comb begin
         sum = '0;
         for (int i = 0; i < NUM_TERMS; i++) begin
            sum = sum + ACC_W'(term_prod(coef[i], feat[i]));
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            go_q      <= 1'b0;
            res_valid <= 1'b0;
            res       <= '0;
         end else begin
            go_q      <= start;
            res_valid <= go_q;
            if (go_q) res <= round_clamp(sum);
         end
      end
   end

endmodule

// File: rtl/thr_window_gen.sv
module thr_window_gen #(
   parameter int WINDOW_LEN = 10000,
   parameter int EPOCH_LEN  = 1000000,
   localparam int WIN_W     = $clog2(WINDOW_LEN + 1),
   localparam int EP_W      = $clog2(EPOCH_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   input  logic [WIN_W-1:0] res,
   output logic             epoch_end,
   output logic             stall,
   output logic [WIN_W-1:0] t_active
);

   logic [WIN_W-1:0] win_q;
   logic [EP_W-1:0]  ep_q;
   logic [WIN_W-1:0] pend_q;
   logic             pend_v_q;
   logic             win_wrap;

   assign win_wrap  = (win_q == WIN_W'(WINDOW_LEN - 1));
   assign epoch_end = (ep_q  == EP_W'(EPOCH_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q    <= '0;
         ep_q     <= '0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
         t_active <= '0;
      end else begin
         win_q <= win_wrap  ? '0 : win_q + WIN_W'(1);
         ep_q  <= epoch_end ? '0 : ep_q  + EP_W'(1);

         // load only when a new window opens
         if (win_wrap && pend_v_q) t_active <= pend_q;

         if (res_valid) begin
            pend_q   <= res;
            pend_v_q <= 1'b1;
         end else if (win_wrap) begin
            pend_v_q <= 1'b0;
         end
      end
   end

   assign stall = (win_q < t_active);

endmodule

// File: rtl/dram_throttle_ctrl.sv
module dram_throttle_ctrl
   import thr_pkg::*;
#(
   parameter int WINDOW_LEN = 10000,
   parameter int EPOCH_LEN  = 1000000,
   parameter int CNT_W      = 20,
   parameter int COEF_W     = 16,
   parameter int PWR_W      = 16,
   parameter int FRAC_W     = 8,
   parameter bit SERIAL_MAC = 1'b1,
   localparam int WIN_W     = $clog2(WINDOW_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [COEF_W-1:0] cfg_wdata,
   input  logic              ev_read,
   input  logic              ev_write,
   input  logic              ev_conflict,
   output logic              stall,
   output logic [WIN_W-1:0]  throttle_delay
);

   // elaboration-time parameter checks
   if (WINDOW_LEN < 16) begin : g_chk_win
      $error("WINDOW_LEN must leave room for the estimator latency");
   end
   if ((EPOCH_LEN % WINDOW_LEN) != 0) begin : g_chk_ep
      $error("EPOCH_LEN must be a whole number of windows");
   end
   if (PWR_W > COEF_W) begin : g_chk_pwr
      $error("PWR_W must fit in the configuration data width");
   end
   if (FRAC_W < 1 || CNT_W < 1) begin : g_chk_w
      $error("FRAC_W and CNT_W must be positive");
   end

   logic [NUM_TERMS-1:0][COEF_W-1:0] coef;
   logic [PWR_W-1:0]                 target;
   logic [NUM_EV-1:0]                ev;
   logic [NUM_EV-1:0][CNT_W-1:0]     counts;
   logic                             epoch_end;
   logic                             res_valid;
   logic [WIN_W-1:0]                 res;

   assign ev[EV_RD] = ev_read;
   assign ev[EV_WR] = ev_write;
   assign ev[EV_CF] = ev_conflict;

   thr_cfg_regs #(
      .COEF_W (COEF_W),
      .PWR_W  (PWR_W)
   ) cfg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .coef   (coef),
      .target (target)
   );

   thr_event_counters #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .epoch_end (epoch_end),
      .snap      (counts)
   );

   thr_estimator #(
      .WINDOW_LEN (WINDOW_LEN),
      .CNT_W      (CNT_W),
      .COEF_W     (COEF_W),
      .PWR_W      (PWR_W),
      .FRAC_W     (FRAC_W),
      .SERIAL_MAC (SERIAL_MAC)
   ) est_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (epoch_end),
      .coef      (coef),
      .target    (target),
      .counts    (counts),
      .res_valid (res_valid),
      .res       (res)
   );

   thr_window_gen #(
      .WINDOW_LEN (WINDOW_LEN),
      .EPOCH_LEN  (EPOCH_LEN)
   ) win_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res       (res),
      .epoch_end (epoch_end),
      .stall     (stall),
      .t_active  (throttle_delay)
   );

endmodule

// File: rtl/dram_throttle_chk.sv
module dram_throttle_chk #(
   parameter int WINDOW_LEN = 10000,
   localparam int WIN_W     = $clog2(WINDOW_LEN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stall,
   input logic [WIN_W-1:0] throttle_delay
);

   // independent window position tracker
   logic [WIN_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                pos_q <= '0;
      else if (pos_q == WIN_W'(WINDOW_LEN - 1))  pos_q <= '0;
      else                                       pos_q <= pos_q + WIN_W'(1);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert (throttle_delay == '0 && !stall); // R1
      end
   end

   AST_STALL_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && pos_q != WIN_W'(WINDOW_LEN - 1)) |=> !stall); // R2

   AST_STALL_LEADS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q == '0 && throttle_delay != '0) |-> stall); // R2

   AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (throttle_delay == '0) |-> !stall); // R3

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (throttle_delay == WIN_W'(WINDOW_LEN)) |-> stall); // R3

   AST_DELAY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      throttle_delay <= WIN_W'(WINDOW_LEN)); // R6

   AST_DELAY_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q != '0) |-> $stable(throttle_delay)); // R7

endmodule

bind dram_throttle_ctrl dram_throttle_chk #(
   .WINDOW_LEN (WINDOW_LEN)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .stall          (stall),
   .throttle_delay (throttle_delay)
);

// File: tb/dram_throttle_ctrl_tb_top.sv
module dram_throttle_ctrl_tb_top;

   localparam int WL     = 20;
   localparam int EL     = 200;
   localparam int CW     = 7;
   localparam int KW     = 16;
   localparam int FW     = 8;
   localparam int WW     = $clog2(WL + 1);
   localparam int CMAX   = (1 << CW) - 1;
   localparam int NEPOCH = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [KW-1:0] cfg_wdata = '0;
   logic          ev_read = 1'b0;
   logic          ev_write = 1'b0;
   logic          ev_conflict = 1'b0;
   logic          stall;
   logic [WW-1:0] throttle_delay;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dram_throttle_ctrl #(
      .WINDOW_LEN (WL),
      .EPOCH_LEN  (EL),
      .CNT_W      (CW),
      .COEF_W     (KW),
      .PWR_W      (16),
      .FRAC_W     (FW),
      .SERIAL_MAC (1'b1)
   ) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_we         (cfg_we),
      .cfg_addr       (cfg_addr),
      .cfg_wdata      (cfg_wdata),
      .ev_read        (ev_read),
      .ev_write       (ev_write),
      .ev_conflict    (ev_conflict),
      .stall          (stall),
      .throttle_delay (throttle_delay)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   longint m_k[5];
   longint m_p;
   int     m_cnt[3];
   int     m_win, m_ep, m_t, m_pend;
   bit     m_pv;

   function automatic int model_eval();
      longint s;
      longint q;
      s = m_k[0] + m_k[1] * m_p + m_k[2] * m_cnt[0] + m_k[3] * m_cnt[1] + m_k[4] * m_cnt[2];
      q = (s + (1 << (FW - 1))) >>> FW;
      if (q < 0)  q = 0;
      if (q > WL) q = WL;
      return int'(q);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) m_k[i] = 0;
         m_p = 0;
         for (int i = 0; i < 3; i++) m_cnt[i] = 0;
         m_win = 0; m_ep = 0; m_t = 0; m_pend = 0; m_pv = 0;
      end else begin
         automatic bit wrap = (m_win == WL - 1);
         automatic bit eend = (m_ep == EL - 1);
         automatic int evs[3];
         evs[0] = ev_read; evs[1] = ev_write; evs[2] = ev_conflict;
         if (wrap && m_pv) begin m_t = m_pend; m_pv = 0; end
         if (eend) begin
            m_pend = model_eval();
            m_pv = 1;
            for (int i = 0; i < 3; i++) m_cnt[i] = evs[i];
         end else begin
            for (int i = 0; i < 3; i++)
               if (evs[i] != 0 && m_cnt[i] < CMAX) m_cnt[i]++;
         end
         if (cfg_we) begin
            if (cfg_addr < 5)       m_k[cfg_addr] = longint'($signed(cfg_wdata));
            else if (cfg_addr == 5) m_p = longint'(cfg_wdata);
         end
         m_win = wrap ? 0 : m_win + 1;
         m_ep  = eend ? 0 : m_ep + 1;
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 stall vs model", int'(stall), (m_win < m_t) ? 1 : 0);
         check("R7 delay vs model", int'(throttle_delay), m_t);
      end
   end

   // ---------------- scenario tables ----------------
   function automatic int cfg_val(input int e, input int a);
      int v[6];
      v = '{0, 0, 0, 0, 0, 0};
      case (e)
         0: v[0] = 1280;
         1: v[0] = -2560;
         2: v[0] = 25600;
         3: v[0] = 128;
         4: v[0] = -128;
         5: v[2] = 64;
         6: v[2] = 16;
         7: begin v[1] = 256; v[3] = -256; v[4] = 512; v[5] = 6; end
         default: v[2] = 1280;
      endcase
      return v[a];
   endfunction

   function automatic bit rd_at(input int e, input int k);
      case (e)
         5: return k < 10;
         6: return 1'b1;
         8: return (k == 0) || (k == 1) || (k == EL - 1);
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit wr_at(input int e, input int k);
      return (e == 7) && (k >= 10) && (k <= 12);
   endfunction

   function automatic bit cf_at(input int e, input int k);
      if (e == 7) return (k >= 20) && (k <= 23);
      return (e < 5) && (k % 7 == 3);
   endfunction

   int exp_t[NEPOCH] = '{5, 0, 20, 1, 0, 3, 8, 11, 10, 5};
   string tag_t[NEPOCH] = '{"R5 bias", "R10 negative bias", "R6 upper clamp",
                            "R5 half rounds up", "R5 minus half", "R5 read term",
                            "R8 saturated reads", "R4 mixed terms",
                            "R4 last-cycle event excluded", "R9 ignored addresses"};

   // ---------------- stimulus ----------------
   initial begin : stim
      repeat (3) @(negedge clk);
      check("R1 reset delay", int'(throttle_delay), 0);
      check("R1 reset stall", int'(stall), 0);
      rst_n = 1'b1;
      for (int g = 0; g < (NEPOCH + 1) * EL + 40; g++) begin
         automatic int e = g / EL;
         automatic int k = g % EL;
         ev_read     = rd_at(e, k);
         ev_write    = wr_at(e, k);
         ev_conflict = cf_at(e, k);
         cfg_we      = 1'b0;
         if (e < NEPOCH && k >= 100 && k <= 107) begin
            cfg_we   = 1'b1;
            cfg_addr = 3'(k - 100);
            if (k <= 105)   cfg_wdata = KW'(cfg_val(e, k - 100));
            else            cfg_wdata = (e == 9) ? 16'h7fff : 16'h1234;
         end
         @(posedge clk);
         @(negedge clk);
         if (g == 210) begin
            check("R1 no estimate yet delay", int'(throttle_delay), 0);
            check("R1 no estimate yet stall", int'(stall), 0);
         end
         if (g == EL + 19 + 4) check("R2 stall inside prefix", int'(stall), 1);
         if (g == EL + 19 + 5) check("R2 stall after prefix", int'(stall), 0);
         if (g == 2 * EL + 19) check("R3 zero delay no stall", int'(stall), 0);
         if (g == 3 * EL + 19 + 19) check("R3 full delay last cycle", int'(stall), 1);
         if (g == EL + 18) check("R7 not loaded one window early", int'(throttle_delay), 0);
         for (int i = 0; i < NEPOCH; i++) begin
            if (g == (i + 1) * EL + 19 + 5)
               check(tag_t[i], int'(throttle_delay), exp_t[i]);
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   // ---------------- watchdog ----------------
   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule